// File: doc/BRIEF.md
# Multi-Mode Microcontroller Expansion Port

This block gives a microcontroller extra I/O pins through a small window of memory-mapped registers. The window is reached only while a chip select for the I/O register space is active. Each pin is set up by two things. The first is a build-time declaration that hands the pin to the on-chip programmable logic. The second, for pins not handed over, is the pair of run-time register bits called mode and direction.

A pin that is not handed over works as a plain GPIO output or input, as an address-out pin, or sits idle. An address-out pin drives one bit of an address captured on the address-latch strobe. A pin handed to the logic takes its output value and output enable from the fabric. A pin declared as a logic input is never driven. A build option removes the mode register altogether; the port then behaves as GPIO only, apart from its declared logic pins.

The input side is brought into the clock domain through a two-flop synchronizer. The synchronized value is read back at register offset 0 and is also passed to the fabric.

Top module: `xport_top`

## Requirements
- R1: After reset the output, direction and mode registers read 0, and every pin not handed to the logic has its output enable low.
- R2: With chip select and write high, a write at byte offset 1 loads the output register, offset 2 loads the direction register and offset 3 loads the mode register. Offset 0 is read-only and a write there changes nothing. A read at offset k returns that register, and offset 0 returns the synchronized pin inputs.
- R3: While chip select is low, writes have no effect and the read data bus is 0.
- R4: A pin with mode bit 0 and direction bit 1 is enabled and drives its output register bit.
- R5: A pin with direction bit 0 and mode bit 0 is not enabled. A pin level applied before a clock edge appears on the offset-0 read after the second edge.
- R6: A pin with mode bit 1 and direction bit 1 is enabled and drives its bit of the address captured on the clock edge where the latch strobe is high.
- R7: A pin with mode bit 1 and direction bit 0 is not enabled.
- R8: On a pin handed to the logic, the output value and enable come from the fabric signals, and the register bits have no effect.
- R9: A pin declared as a logic input keeps its output enable low whatever its direction bit and the fabric enable are.
- R10: When built without a mode register, offset 3 reads 0, writes there are ignored, and the pins handed to nobody act as GPIO.
- R11: The fabric input bus equals the pin inputs delayed by two clock edges.
- R12: Any pin whose output enable is low presents 0 on its output value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select for the I/O register window |
| we | input | 1 | Write strobe, qualified by cs |
| addr | input | 2 | Register byte offset |
| wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Read data, 0 while cs is low |
| ale | input | 1 | Address latch strobe |
| addrIn | input | WIDTH | Address bits to capture |
| pinIn | input | WIDTH | Pad input levels |
| pinOut | output | WIDTH | Pad output values |
| pinOe | output | WIDTH | Pad output enables |
| fabOut | input | WIDTH | Output values from the logic fabric |
| fabOe | input | WIDTH | Output enables from the logic fabric |
| fabIn | output | WIDTH | Synchronized pad levels to the fabric |

## Verification
Directed sequences step through the mode and direction combinations one at a time. One sets GPIO output with a mixed data pattern, where only direction-selected bits may show. One sets address-out with an address whose bits differ from the output register, so a wrong source is visible. One sets the idle setting, where a stuck enable shows. The directed part finishes with writes under a low chip select and at the read-only offset. Fabric patterns drive full enables on both logic pins, which tells the logic-input pin apart from the bidirectional one. Fabric values are also set that conflict with the register bits. A long stretch of random bus, pad, latch and fabric traffic is then compared cycle by cycle against a behavioural model for two build variants, with and without the mode register.

// File: rtl/xport_pkg.sv
package xport_pkg;
  typedef enum logic [1:0] {
    OFS_DIN  = 2'd0,
    OFS_DOUT = 2'd1,
    OFS_DIR  = 2'd2,
    OFS_MODE = 2'd3
  } regOfs_e;

  typedef struct packed {
    logic    wrOut;
    logic    wrDir;
    logic    wrMode;
    logic    latchAddr;
    logic    rdEn;
    regOfs_e rdSel;
  } ctlStrobes_t;
endpackage

// File: rtl/xport_ctrl.sv
module xport_ctrl
  import xport_pkg::*;
#(
  parameter bit HAS_MODE = 1'b1
) (
  input  logic        cs,
  input  logic        we,
  input  logic [1:0]  addr,
  input  logic        ale,
  output ctlStrobes_t strb
);
  regOfs_e ofs;
  logic    wrHit;

  assign ofs   = regOfs_e'(addr);
  assign wrHit = cs & we;

  always_comb begin
    strb           = '0;
    strb.rdEn      = cs;
    strb.rdSel     = ofs;
    strb.wrOut     = wrHit && (ofs == OFS_DOUT);
    strb.wrDir     = wrHit && (ofs == OFS_DIR);
    strb.wrMode    = HAS_MODE && wrHit && (ofs == OFS_MODE);
    strb.latchAddr = ale;
  end
endmodule

// File: rtl/xport_dp.sv
module xport_dp
  import xport_pkg::*;
#(
  parameter int               WIDTH       = 8,
  parameter bit               HAS_MODE    = 1'b1,
  parameter logic [WIDTH-1:0] FAB_PINS    = '0,
  parameter logic [WIDTH-1:0] FAB_IN_PINS = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctlStrobes_t      strb,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] addrIn,
  input  logic [WIDTH-1:0] pinIn,
  input  logic [WIDTH-1:0] fabOut,
  input  logic [WIDTH-1:0] fabOe,
  output logic [WIDTH-1:0] rdata,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe,
  output logic [WIDTH-1:0] fabIn
);
  localparam logic [WIDTH-1:0] NO_DRIVE = FAB_PINS & FAB_IN_PINS;

  logic [WIDTH-1:0] outReg, dirReg, modeReg, addrReg;
  logic [WIDTH-1:0] syncA, syncB;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outReg  <= '0;
      dirReg  <= '0;
      addrReg <= '0;
      syncA   <= '0;
      syncB   <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      if (strb.wrOut)     outReg  <= wdata;
      if (strb.wrDir)     dirReg  <= wdata;
      if (strb.latchAddr) addrReg <= addrIn;
    end
  end

  generate
    if (HAS_MODE) begin : g_mode
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           modeReg <= '0;
        else if (strb.wrMode) modeReg <= wdata;
      end
    end else begin : g_nomode
      assign modeReg = '0;
    end
  endgenerate

  always_comb begin
    rdata = '0;
    if (strb.rdEn) begin
      unique case (strb.rdSel)
        OFS_DIN:  rdata = syncB;
        OFS_DOUT: rdata = outReg;
        OFS_DIR:  rdata = dirReg;
        OFS_MODE: rdata = modeReg;
        default:  rdata = '0;
      endcase
    end
  end

  assign fabIn = syncB;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic bitOut, bitOe;
    if (FAB_PINS[i]) begin : g_fab
      assign bitOe  = NO_DRIVE[i] ? 1'b0 : fabOe[i];
      assign bitOut = bitOe & fabOut[i];
    end else begin : g_reg
      always_comb begin
        if (modeReg[i]) begin
          bitOe  = dirReg[i];
          bitOut = dirReg[i] & addrReg[i];
        end else begin
          bitOe  = dirReg[i];
          bitOut = dirReg[i] & outReg[i];
        end
      end
    end
    assign pinOut[i] = bitOut;
    assign pinOe[i]  = bitOe;
  end
endmodule

// File: rtl/xport_top.sv
module xport_top
  import xport_pkg::*;
#(
  parameter int               WIDTH       = 8,
  parameter bit               HAS_MODE    = 1'b1,
  parameter logic [WIDTH-1:0] FAB_PINS    = 8'hC0,
  parameter logic [WIDTH-1:0] FAB_IN_PINS = 8'h80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  input  logic             ale,
  input  logic [WIDTH-1:0] addrIn,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe,
  input  logic [WIDTH-1:0] fabOut,
  input  logic [WIDTH-1:0] fabOe,
  output logic [WIDTH-1:0] fabIn
);
  ctlStrobes_t strb;

  xport_ctrl #(.HAS_MODE(HAS_MODE)) ctrl_i (
    .cs(cs), .we(we), .addr(addr), .ale(ale), .strb(strb)
  );

  xport_dp #(
    .WIDTH(WIDTH), .HAS_MODE(HAS_MODE),
    .FAB_PINS(FAB_PINS), .FAB_IN_PINS(FAB_IN_PINS)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wdata(wdata),
    .addrIn(addrIn), .pinIn(pinIn), .fabOut(fabOut), .fabOe(fabOe),
    .rdata(rdata), .pinOut(pinOut), .pinOe(pinOe), .fabIn(fabIn)
  );
endmodule

// File: rtl/xport_chk.sv
module xport_chk #(
  parameter int               WIDTH       = 8,
  parameter logic [WIDTH-1:0] FAB_PINS    = '0,
  parameter logic [WIDTH-1:0] FAB_IN_PINS = '0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs,
  input logic             we,
  input logic [1:0]       addr,
  input logic [WIDTH-1:0] wdata,
  input logic [WIDTH-1:0] rdata,
  input logic [WIDTH-1:0] pinIn,
  input logic [WIDTH-1:0] pinOut,
  input logic [WIDTH-1:0] pinOe,
  input logic [WIDTH-1:0] fabIn
);
  localparam logic [WIDTH-1:0] IN_ONLY = FAB_PINS & FAB_IN_PINS;

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= '0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  p_rd_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> (rdata == '0));

  p_wr_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && we && addr == 2'd1) |=> (!(cs && addr == 2'd1) || rdata == $past(wdata)));

  p_in_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pinOe & IN_ONLY) == '0);

  p_sync_depth_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> (fabIn == $past(pinIn, 2)));

  p_quiet_pin_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (pinOut & ~pinOe) == '0);
endmodule

bind xport_top xport_chk #(
  .WIDTH(WIDTH), .FAB_PINS(FAB_PINS), .FAB_IN_PINS(FAB_IN_PINS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr),
  .wdata(wdata), .rdata(rdata), .pinIn(pinIn), .pinOut(pinOut),
  .pinOe(pinOe), .fabIn(fabIn)
);

// File: tb/xport_top_tb_top.sv
module xport_top_tb_top;
  localparam int         W   = 8;
  localparam logic [7:0] FAB = 8'hC0;
  localparam logic [7:0] FIN = 8'h80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 0, we = 0, ale = 0;
  logic [1:0] addr = 0;
  logic [W-1:0] wdata = 0, addrIn = 0, pinIn = 0, fabOut = 0, fabOe = 0;
  logic [W-1:0] rdata0, pinOut0, pinOe0, fabIn0;
  logic [W-1:0] rdata1, pinOut1, pinOe1, fabIn1;

  int nChecks = 0, nErr = 0;
  bit done = 0;

  always #10 clk = ~clk;

  xport_top #(.WIDTH(W), .HAS_MODE(1'b1), .FAB_PINS(FAB), .FAB_IN_PINS(FIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata0), .ale(ale), .addrIn(addrIn), .pinIn(pinIn), .pinOut(pinOut0),
    .pinOe(pinOe0), .fabOut(fabOut), .fabOe(fabOe), .fabIn(fabIn0));

  xport_top #(.WIDTH(W), .HAS_MODE(1'b0), .FAB_PINS(FAB), .FAB_IN_PINS(FIN)) nctl_i (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata1), .ale(ale), .addrIn(addrIn), .pinIn(pinIn), .pinOut(pinOut1),
    .pinOe(pinOe1), .fabOut(fabOut), .fabOe(fabOe), .fabIn(fabIn1));

  // behavioural reference state, index 0 = with mode register, 1 = without
  int mOut[2], mDir[2], mMode[2];
  int mAddr, syn1, syn2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin mOut[k] = 0; mDir[k] = 0; mMode[k] = 0; end
      mAddr = 0; syn1 = 0; syn2 = 0;
    end else begin
      syn2 = syn1;
      syn1 = int'(pinIn);
      if (ale) mAddr = int'(addrIn);
      if (cs && we) begin
        for (int k = 0; k < 2; k++) begin
          if (addr == 2'd1) mOut[k] = int'(wdata);
          if (addr == 2'd2) mDir[k] = int'(wdata);
          if (addr == 2'd3 && k == 0) mMode[k] = int'(wdata);
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int expRd(input int k);
    if (!cs) return 0;
    case (addr)
      2'd0: return syn2;
      2'd1: return mOut[k];
      2'd2: return mDir[k];
      default: return mMode[k];
    endcase
  endfunction

  function automatic void expPins(input int k, output int eo, output int ee);
    eo = 0; ee = 0;
    for (int b = 0; b < W; b++) begin
      int o, e;
      if (FAB[b]) begin
        e = FIN[b] ? 0 : int'(fabOe[b]);
        o = e & int'(fabOut[b]);
      end else if ((mMode[k] >> b) & 1) begin
        e = (mDir[k] >> b) & 1;
        o = e & ((mAddr >> b) & 1);
      end else begin
        e = (mDir[k] >> b) & 1;
        o = e & ((mOut[k] >> b) & 1);
      end
      eo |= o << b;
      ee |= e << b;
    end
  endfunction

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      int eo, ee;
      expPins(0, eo, ee);
      chk("R2 rdata mode-variant", int'(rdata0), expRd(0));
      chk("R4 pinOut mode-variant", int'(pinOut0), eo);
      chk("R4 pinOe mode-variant", int'(pinOe0), ee);
      chk("R11 fabIn mode-variant", int'(fabIn0), syn2);
      expPins(1, eo, ee);
      chk("R10 rdata no-mode", int'(rdata1), expRd(1));
      chk("R10 pinOut no-mode", int'(pinOut1), eo);
      chk("R10 pinOe no-mode", int'(pinOe1), ee);
      chk("R11 fabIn no-mode", int'(fabIn1), syn2);
    end
  end

  task automatic busWr(input int a, input int d);
    @(negedge clk); #1;
    cs = 1; we = 1; addr = 2'(a); wdata = 8'(d);
    @(negedge clk); #1;
    cs = 0; we = 0;
  endtask

  task automatic selRd(input int a);
    #1; cs = 1; we = 0; addr = 2'(a);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      nChecks++; nErr++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    // R1: reset values
    selRd(1); chk("R1 out reg", int'(rdata0), 0);
    selRd(2); chk("R1 dir reg", int'(rdata0), 0);
    selRd(3); chk("R1 mode reg", int'(rdata0), 0);
    chk("R1 oe low", int'(pinOe0 & 8'h3F), 0);
    #1 cs = 0;
    // R4: GPIO outputs
    busWr(1, 8'hA5);
    busWr(2, 8'h0F);
    @(negedge clk);
    chk("R4 oe", int'(pinOe0 & 8'h3F), 8'h0F);
    chk("R4 out", int'(pinOut0 & 8'h3F), 8'h05);
    // R5 / R11: input sync depth
    #1 pinIn = 8'h3C; cs = 1; addr = 0;
    @(negedge clk);
    chk("R5 one edge", int'(rdata0), 0);
    @(negedge clk);
    chk("R5 two edges", int'(rdata0), 8'h3C);
    chk("R11 fabIn", int'(fabIn0), 8'h3C);
    chk("R5 input pins idle", int'(pinOe0 & 8'h30), 0);
    #1 cs = 0;
    // R2: write to read-only offset ignored
    busWr(0, 8'hFF);
    selRd(0); chk("R2 din unchanged", int'(rdata0), 8'h3C);
    #1 cs = 0;
    // R3: writes with cs low ignored
    #1 we = 1; addr = 1; wdata = 8'h00;
    @(negedge clk);
    chk("R3 rdata idle", int'(rdata0), 0);
    #1 we = 0;
    selRd(1); chk("R3 out reg kept", int'(rdata0), 8'hA5);
    #1 cs = 0;
    // R6: address-out on pins 4,5
    #1 ale = 1; addrIn = 8'h5A;
    @(negedge clk); #1 ale = 0; addrIn = 8'h00;
    busWr(3, 8'h30);
    busWr(2, 8'h3F);
    @(negedge clk);
    chk("R6 oe", int'(pinOe0 & 8'h3F), 8'h3F);
    chk("R6 out", int'(pinOut0 & 8'h3F), 8'h15);
    // R7: mode 1 direction 0
    busWr(2, 8'h0F);
    @(negedge clk);
    chk("R7 oe", int'(pinOe0 & 8'h30), 0);
    chk("R12 quiet out", int'(pinOut0 & 8'h30), 0);
    // R8 / R9: fabric pins
    busWr(2, 8'hFF);
    #1 fabOe = 8'hFF; fabOut = 8'hC0;
    @(negedge clk);
    chk("R8 fab oe", int'(pinOe0 & 8'hC0), 8'h40);
    chk("R8 fab out", int'(pinOut0 & 8'hC0), 8'h40);
    chk("R9 logic input", int'(pinOe0[7]), 0);
    #1 fabOe = 8'h00;
    @(negedge clk);
    chk("R8 dir ignored", int'(pinOe0 & 8'hC0), 0);
    // R10: variant without mode register
    busWr(3, 8'hFF);
    selRd(3); chk("R10 mode reads 0", int'(rdata1), 0);
    chk("R10 gpio oe", int'(pinOe1 & 8'h3F), 8'h3F);
    chk("R10 gpio out", int'(pinOut1 & 8'h3F), 8'h25);
    #1 cs = 0;
    // random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk); #1;
      cs = 1'($urandom); we = 1'($urandom); addr = 2'($urandom);
      wdata = 8'($urandom); pinIn = 8'($urandom); ale = ($urandom % 4) == 0;
      addrIn = 8'($urandom); fabOut = 8'($urandom); fabOe = 8'($urandom);
    end
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule